// File: doc/BRIEF.md
# Base-Index-Displacement Effective Address Generator

This block turns the three address fields of a storage-operand instruction into an effective address. It takes a base register number, an index register number and an unsigned 12-bit displacement. It looks up the two registers in a 16-entry, 64-bit general register file through two combinational read ports. Register number 0 in either field contributes zero, whatever the register holds. The three terms are summed, the sum is cut down to the active addressing mode, and the low bits of the result are checked against the natural alignment of the operand size.

The operation is started by a one-cycle valid strobe. One cycle later the block presents the registered address and exception flag, together with a one-cycle done pulse. The register file sits outside the block. The block drives its read addresses straight from the register-number inputs and takes the read data back in the same cycle. Translation to real storage and the storage access itself happen downstream.

Control is a two-state machine. `ST_IDLE` is the reset state, in which no result is being presented. `ST_RESULT` is the state in which done is high. The transition `GO_RESULT` is taken on any edge where valid is high, from either state, so back-to-back strobes keep the machine in `ST_RESULT`. The transition `GO_IDLE` is taken on any edge where valid is low.

Top module: `bdx_agen`

## Requirements
- R1: While reset is asserted and after its release with no strobe, `done_o` is 0, `spec_exc_o` is 0 and `ea_o` is 0.
- R2: `gr_addr_a_o` equals `base_sel_i` and `gr_addr_b_o` equals `index_sel_i` in the same cycle, with no register in between.
- R3: A base register number of 0 adds zero to the sum, even when register 0 holds a nonzero value.
- R4: An index register number of 0 adds zero to the sum, even when register 0 holds a nonzero value.
- R5: With `amode_i` = 2 or 3 (64-bit), `ea_o` is base + index + displacement modulo 2^64, where the displacement is zero-extended.
- R6: With `amode_i` = 1 (31-bit), `ea_o` is the same sum with bits 63..31 forced to 0.
- R7: With `amode_i` = 0 (24-bit), `ea_o` is the same sum with bits 63..24 forced to 0, so it never reaches 0x01000000.
- R8: `spec_exc_o` is 1 when the truncated address is misaligned for `size_i`. Size 0 is a halfword and needs bit 0 clear. Size 1 is a fullword and needs bits 1..0 clear. Sizes 2 and 3 are a doubleword and need bits 2..0 clear.
- R9: A strobe on clock edge k makes `done_o` high for the cycle after edge k, with `ea_o` and `spec_exc_o` for that strobe. Strobes on consecutive edges each produce their own result in consecutive cycles.
- R10: In a cycle not preceded by a strobe, `done_o` and `spec_exc_o` are 0 and `ea_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Start strobe, one cycle per operation |
| base_sel_i | input | 4 | Base register number |
| index_sel_i | input | 4 | Index register number |
| disp_i | input | 12 | Unsigned displacement |
| amode_i | input | 2 | Addressing mode: 0 = 24-bit, 1 = 31-bit, 2 or 3 = 64-bit |
| size_i | input | 2 | Operand size: 0 = halfword, 1 = fullword, 2 or 3 = doubleword |
| gr_addr_a_o | output | 4 | Register file read address, base port |
| gr_data_a_i | input | 64 | Register file read data, base port |
| gr_addr_b_o | output | 4 | Register file read address, index port |
| gr_data_b_i | input | 64 | Register file read data, index port |
| ea_o | output | 64 | Registered effective address |
| spec_exc_o | output | 1 | Registered misalignment (specification) exception |
| done_o | output | 1 | Result-valid pulse |

## Verification
In the bench, register 0 holds a nonzero pattern. A design that read register 0 as a base or index would therefore show that pattern in the address. Register 15 holds a value near the top of the 64-bit range, and adding the largest displacement to it must wrap. A design that saturated the sum, or kept a carry, would give the wrong 64-bit result. The sweep covers every base and index pair in all three modes. The masks and the misalignment flag are compared against arithmetic results. This exposes a wrong mask width, such as 32 bits where 31 are required, or an alignment test on the wrong bits. Back-to-back strobes and idle cycles expose a done pulse that stretches, a result that is dropped, and a flag that stays high after its pulse.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

    typedef enum logic [1:0] {
        AM_24    = 2'd0,
        AM_31    = 2'd1,
        AM_64    = 2'd2,
        AM_64ALT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SZ_HALF   = 2'd0,
        SZ_FULL   = 2'd1,
        SZ_DBL    = 2'd2,
        SZ_DBLALT = 2'd3
    } opsize_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } agen_state_e;

endpackage

// File: rtl/bdx_gr_port.sv
// One register-file read port: register number 0 reads as zero.
module bdx_gr_port #(
    parameter int XLEN  = 64,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [XLEN-1:0]  rd_data_i,
    output logic [SEL_W-1:0] rd_addr_o,
    output logic [XLEN-1:0]  value_o
);
    assign rd_addr_o = sel_i;

    always_comb begin
        if (sel_i == '0) begin
            value_o = '0;
        end else begin
            value_o = rd_data_i;
        end
    end
endmodule

// File: rtl/bdx_ea_calc.sv
// Sum, mode truncation and alignment test.
module bdx_ea_calc
    import bdx_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int DISP_W = 12,
    parameter int A24_W  = 24,
    parameter int A31_W  = 31
) (
    input  logic [XLEN-1:0]   base_v_i,
    input  logic [XLEN-1:0]   index_v_i,
    input  logic [DISP_W-1:0] disp_i,
    input  amode_e            amode_i,
    input  opsize_e           size_i,
    output logic [XLEN-1:0]   ea_o,
    output logic              misalign_o
);
    localparam logic [XLEN-1:0] MASK_24 = {{(XLEN-A24_W){1'b0}}, {A24_W{1'b1}}};
    localparam logic [XLEN-1:0] MASK_31 = {{(XLEN-A31_W){1'b0}}, {A31_W{1'b1}}};

    logic [XLEN-1:0] sum;

    assign sum = base_v_i + index_v_i + {{(XLEN-DISP_W){1'b0}}, disp_i};

    always_comb begin
        unique case (amode_i)
            AM_24:   ea_o = sum & MASK_24;
            AM_31:   ea_o = sum & MASK_31;
            default: ea_o = sum;
        endcase
    end

    // alignment is judged on the truncated address
    always_comb begin
        unique case (size_i)
            SZ_HALF: misalign_o = ea_o[0];
            SZ_FULL: misalign_o = |ea_o[1:0];
            default: misalign_o = |ea_o[2:0];
        endcase
    end
endmodule

// File: rtl/bdx_agen.sv
module bdx_agen
    import bdx_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREGS  = 16,
    parameter int DISP_W = 12,
    parameter int A24_W  = 24,
    parameter int A31_W  = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic [$clog2(NREGS)-1:0] base_sel_i,
    input  logic [$clog2(NREGS)-1:0] index_sel_i,
    input  logic [DISP_W-1:0]        disp_i,
    input  logic [1:0]               amode_i,
    input  logic [1:0]               size_i,
    output logic [$clog2(NREGS)-1:0] gr_addr_a_o,
    input  logic [XLEN-1:0]          gr_data_a_i,
    output logic [$clog2(NREGS)-1:0] gr_addr_b_o,
    input  logic [XLEN-1:0]          gr_data_b_i,
    output logic [XLEN-1:0]          ea_o,
    output logic                     spec_exc_o,
    output logic                     done_o
);
    localparam int SEL_W  = $clog2(NREGS);
    localparam int NPORTS = 2;

    logic [SEL_W-1:0] port_sel  [NPORTS];
    logic [SEL_W-1:0] port_addr [NPORTS];
    logic [XLEN-1:0]  port_data [NPORTS];
    logic [XLEN-1:0]  port_val  [NPORTS];

    assign port_sel[0]  = base_sel_i;
    assign port_sel[1]  = index_sel_i;
    assign port_data[0] = gr_data_a_i;
    assign port_data[1] = gr_data_b_i;
    assign gr_addr_a_o  = port_addr[0];
    assign gr_addr_b_o  = port_addr[1];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        bdx_gr_port #(.XLEN(XLEN), .SEL_W(SEL_W)) u_port (
            .sel_i     (port_sel[p]),
            .rd_data_i (port_data[p]),
            .rd_addr_o (port_addr[p]),
            .value_o   (port_val[p])
        );
    end

    logic [XLEN-1:0] ea_calc;
    logic            misalign;

    bdx_ea_calc #(
        .XLEN(XLEN), .DISP_W(DISP_W), .A24_W(A24_W), .A31_W(A31_W)
    ) u_calc (
        .base_v_i   (port_val[0]),
        .index_v_i  (port_val[1]),
        .disp_i     (disp_i),
        .amode_i    (amode_e'(amode_i)),
        .size_i     (opsize_e'(size_i)),
        .ea_o       (ea_calc),
        .misalign_o (misalign)
    );

    // ---------------- state machine ----------------
    agen_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = valid_i ? ST_RESULT : ST_IDLE;   // GO_RESULT
            ST_RESULT: state_d = valid_i ? ST_RESULT : ST_IDLE;   // GO_IDLE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- outputs ----------------
    logic [XLEN-1:0] ea_q;
    logic            spec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            spec_q <= 1'b0;
        end else begin
            spec_q <= 1'b0;
            if (valid_i) begin
                ea_q   <= ea_calc;
                spec_q <= misalign;
            end
        end
    end

    assign ea_o       = ea_q;
    assign spec_exc_o = spec_q;
    assign done_o     = (state_q == ST_RESULT);

    // ---------------- assertions ----------------
    assert_done_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!done_o && !spec_exc_o && $stable(ea_o)));

    assert_mode24_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && amode_i == AM_24) |=> (ea_o[XLEN-1:A24_W] == '0));

    assert_mode31_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && amode_i == AM_31) |=> (ea_o[XLEN-1:A31_W] == '0));

    assert_dbl_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && size_i == SZ_DBL) |=> (spec_exc_o == (ea_o[2:0] != 3'b000)));

    // R3 and R4: both fields zero leaves only the displacement
    assert_zero_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && base_sel_i == '0 && index_sel_i == '0 && amode_i == AM_64)
        |=> (ea_o == {{(XLEN-DISP_W){1'b0}}, $past(disp_i)}));

endmodule

// File: tb/bdx_agen_test.sv
module bdx_agen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  base_sel_i = '0;
    logic [3:0]  index_sel_i = '0;
    logic [11:0] disp_i = '0;
    logic [1:0]  amode_i = '0;
    logic [1:0]  size_i = '0;
    logic [3:0]  gr_addr_a_o, gr_addr_b_o;
    logic [63:0] gr_data_a_i, gr_data_b_i;
    logic [63:0] ea_o;
    logic        spec_exc_o, done_o;

    logic [63:0] gr [16];
    int checks = 0;
    int fails  = 0;
    logic [63:0] last_ea = '0;

    always #2.5 clk = ~clk;

    assign gr_data_a_i = gr[gr_addr_a_o];
    assign gr_data_b_i = gr[gr_addr_b_o];

    bdx_agen uut (
        .clk, .rst_n, .valid_i, .base_sel_i, .index_sel_i, .disp_i,
        .amode_i, .size_i, .gr_addr_a_o, .gr_data_a_i, .gr_addr_b_o,
        .gr_data_b_i, .ea_o, .spec_exc_o, .done_o
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ea(input int b, input int x, input int d, input int m);
        logic [63:0] s;
        s = (b == 0 ? 64'd0 : gr[b]) + (x == 0 ? 64'd0 : gr[x]) + 64'(d);
        if (m == 0) s = s & 64'h0000_0000_00FF_FFFF;
        else if (m == 1) s = s & 64'h0000_0000_7FFF_FFFF;
        return s;
    endfunction

    function automatic bit exp_spec(input logic [63:0] a, input int sz);
        if (sz == 0) return a[0];
        if (sz == 1) return a[1:0] != 2'b00;
        return a[2:0] != 3'b000;
    endfunction

    function automatic string mode_tag(input int m);
        if (m == 0) return "R7";
        if (m == 1) return "R6";
        return "R5";
    endfunction

    task automatic drive(input int b, input int x, input int d, input int m, input int s);
        base_sel_i  = 4'(b);
        index_sel_i = 4'(x);
        disp_i      = 12'(d);
        amode_i     = 2'(m);
        size_i      = 2'(s);
        valid_i     = 1'b1;
    endtask

    task automatic check_result(input int b, input int x, input int d, input int m, input int s, input string tag);
        logic [63:0] e;
        e = exp_ea(b, x, d, m);
        chk(done_o === 1'b1, "R9 done", 64'(done_o), 64'd1);
        chk(ea_o === e, tag, ea_o, e);
        chk(spec_exc_o === exp_spec(e, s), "R8 spec", 64'(spec_exc_o), 64'(exp_spec(e, s)));
        last_ea = e;
    endtask

    // single operation: idle check, strobe, result check
    task automatic run_op(input int b, input int x, input int d, input int m, input int s, input string tag);
        @(negedge clk);
        chk(done_o === 1'b0 && spec_exc_o === 1'b0, "R10 idle flags", {62'd0, done_o, spec_exc_o}, 64'd0);
        chk(ea_o === last_ea, "R10 hold", ea_o, last_ea);
        drive(b, x, d, m, s);
        @(negedge clk);
        valid_i = 1'b0;
        check_result(b, x, d, m, s, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        gr[0] = 64'hDEAD_BEEF_0BAD_F00D;
        for (int i = 1; i < 15; i++) begin
            gr[i] = {32'(i) * 32'h1357_9BDF, 32'(i) * 32'h2468_ACE1};
        end
        gr[15] = 64'hFFFF_FFFF_FFFF_F001;

        repeat (3) @(negedge clk);
        chk(done_o === 1'b0 && spec_exc_o === 1'b0, "R1 flags in reset", {62'd0, done_o, spec_exc_o}, 64'd0);
        chk(ea_o === 64'd0, "R1 ea in reset", ea_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o === 1'b0 && ea_o === 64'd0, "R1 after reset", ea_o, 64'd0);

        // R2: combinational read addresses
        base_sel_i = 4'd9; index_sel_i = 4'd3; #1;
        chk(gr_addr_a_o === 4'd9, "R2 port a", 64'(gr_addr_a_o), 64'd9);
        chk(gr_addr_b_o === 4'd3, "R2 port b", 64'(gr_addr_b_o), 64'd3);

        // R3 / R4: register 0 in either field
        run_op(0, 5, 12'h123, 2, 2, "R3 base zero");
        run_op(5, 0, 12'h123, 2, 2, "R4 index zero");
        run_op(0, 0, 12'hFFF, 2, 0, "R3 R4 both zero");
        // R5: wraparound and largest displacement
        run_op(15, 15, 4095, 2, 2, "R5 wrap");
        run_op(15, 0, 4095, 3, 1, "R5 mode 3");
        // R7 / R6 truncation of wrapped sum
        run_op(15, 14, 4095, 0, 0, "R7 wrap 24");
        run_op(15, 14, 4095, 1, 1, "R6 wrap 31");

        // sweep: all pairs, three modes, all sizes
        for (int m = 0; m < 3; m++) begin
            for (int b = 0; b < 16; b++) begin
                for (int x = 0; x < 16; x++) begin
                    run_op(b, x, (b * 37 + x * 101 + m * 7) % 4096, m, (b + x + m) % 4, mode_tag(m));
                end
            end
        end

        // R9: back-to-back strobes
        @(negedge clk);
        drive(3, 4, 12'h011, 2, 1);
        @(negedge clk);
        drive(7, 2, 12'h006, 0, 2);
        check_result(3, 4, 12'h011, 2, 1, "R9 b2b first");
        @(negedge clk);
        valid_i = 1'b0;
        check_result(7, 2, 12'h006, 0, 2, "R9 b2b second");
        @(negedge clk);
        chk(done_o === 1'b0, "R9 pulse ends", 64'(done_o), 64'd0);
        chk(ea_o === last_ea, "R10 hold after b2b", ea_o, last_ea);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule